// File: doc/BRIEF.md
# USB Endpoint Data Toggle Tracker

This block keeps the DATA0/DATA1 sequence state for every endpoint of a USB device. Each endpoint owns one stored toggle bit. When the receive path accepts a data packet for an endpoint, the block compares the packet's PID with the PID that endpoint expects next. A packet that matches moves the endpoint along the sequence. A packet that does not match leaves the state alone; it is taken to be a retry of a packet that was already seen. Control transfers get special handling: SETUP data always restarts the endpoint at DATA0, and a status-stage transmit always goes out as DATA1.

Software can clear a single endpoint, for example after a halt on that endpoint is cleared. A USB bus reset clears every endpoint in the same cycle. Isochronous endpoints do not use the toggle. For them the block raises a not-applicable flag, and received packets leave the stored bit unchanged.

A query port takes an endpoint number, its type and a status-stage flag. It returns, from the stored state with no register in the path, the endpoint's toggle bit and the PID to use for the next transmission.

Top module: `dtog_tracker`

## Requirements
- R1: After reset every endpoint's toggle bit reads 0 and the next transmit PID is DATA0. PID encoding on every port: 0 = DATA0, 1 = DATA1. Endpoint type encoding: 2'b00 control, 2'b01 isochronous, 2'b10 bulk, 2'b11 interrupt.
- R2: On a non-isochronous endpoint, an accepted non-SETUP packet whose PID equals the stored bit (bit 1 means DATA1 is expected) updates the bit: DATA0 sets it to 1 and DATA1 clears it to 0.
- R3: An accepted non-SETUP packet whose PID differs from the stored bit leaves that endpoint's bit unchanged.
- R4: An accepted SETUP packet on a control endpoint sets the bit to 1 (DATA0 received) whatever its PID and the prior state. The SETUP flag on any other endpoint type makes the packet have no effect.
- R5: A software endpoint reset clears only the named endpoint's bit. In the same cycle it wins over a received packet for that endpoint.
- R6: A bus reset clears the bits of all endpoints. It wins over every other event in that cycle.
- R7: For a non-isochronous query the transmit PID equals the stored bit, except that a status-stage query always gives DATA1.
- R8: For an isochronous query the not-applicable flag is 1 and the transmit PID is DATA0. For other types the flag is 0. Packets marked isochronous never change the stored bit.
- R9: An update becomes visible on the query outputs in the cycle after the strobe, and it touches only the addressed endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | USB bus reset, clears all endpoints |
| ep_rst_i | input | 1 | Software reset strobe for one endpoint |
| ep_rst_num_i | input | EPW | Endpoint cleared by ep_rst_i |
| rx_valid_i | input | 1 | Accepted data packet strobe |
| rx_ep_i | input | EPW | Endpoint of the accepted packet |
| rx_pid_i | input | 1 | Packet PID (0 DATA0, 1 DATA1) |
| rx_setup_i | input | 1 | Packet is the data of a SETUP transaction |
| rx_kind_i | input | 2 | Type of the receiving endpoint |
| q_ep_i | input | EPW | Endpoint being queried |
| q_kind_i | input | 2 | Type of the queried endpoint |
| q_status_i | input | 1 | Queried endpoint is in its status stage |
| q_toggle_o | output | 1 | Stored toggle bit of the queried endpoint |
| q_tx_pid_o | output | 1 | PID for the next transmission |
| q_na_o | output | 1 | Toggle not applicable (isochronous) |

## Verification
The hardest case to reach from the ports is a collision in one cycle: a received packet aimed at an endpoint that a software reset or a bus reset is clearing in the same cycle. The reset has to win, and neighbouring endpoints must keep their state. Directed steps first set up a known non-zero bit and then drive the packet and the reset together. The random phase picks from a small range of endpoint numbers, so the packet endpoint and the reset endpoint coincide often. Retries with a mismatched PID come from random PIDs, and each one is checked by a later query of the same endpoint.

// File: rtl/dtog_pkg.sv
package dtog_pkg;
   typedef enum logic [1:0] {
      EP_CTRL = 2'b00,
      EP_ISO  = 2'b01,
      EP_BULK = 2'b10,
      EP_INTR = 2'b11
   } ep_kind_t;

   localparam logic PID_DATA0 = 1'b0;
   localparam logic PID_DATA1 = 1'b1;

   // A stored bit of 1 means the endpoint expects DATA1 next.
   function automatic logic pid_matches(input logic stored, input logic pid);
      return pid == stored;
   endfunction

   // Value stored after a matching packet: DATA0 sets, DATA1 clears.
   function automatic logic bit_after(input logic pid);
      return pid == PID_DATA0;
   endfunction
endpackage

// File: rtl/dtog_rx_decode.sv
module dtog_rx_decode
   import dtog_pkg::*;
#(
   parameter int NUM_EP = 8,
   parameter int EPW    = 3
) (
   input  logic              bus_rst_i,
   input  logic              ep_rst_i,
   input  logic [EPW-1:0]    ep_rst_num_i,
   input  logic              rx_valid_i,
   input  logic [EPW-1:0]    rx_ep_i,
   input  logic              rx_pid_i,
   input  logic              rx_setup_i,
   input  logic [1:0]        rx_kind_i,
   input  logic [NUM_EP-1:0] cur_i,
   output logic [NUM_EP-1:0] load_en_o,
   output logic [NUM_EP-1:0] load_val_o
);
   logic     rx_is_ctrl;
   logic     rx_is_iso;
   ep_kind_t kind;

   assign kind       = ep_kind_t'(rx_kind_i);
   assign rx_is_ctrl = (kind == EP_CTRL);
   assign rx_is_iso  = (kind == EP_ISO);

   for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      logic sel_rx;
      logic sel_rst;
      logic setup_hit;
      logic data_hit;

      assign sel_rx    = rx_valid_i && (int'(rx_ep_i) == g) && !rx_is_iso;
      assign sel_rst   = ep_rst_i && (int'(ep_rst_num_i) == g);
      assign setup_hit = sel_rx && rx_setup_i && rx_is_ctrl;
      assign data_hit  = sel_rx && !rx_setup_i && pid_matches(cur_i[g], rx_pid_i);

      always_comb begin
         load_en_o[g]  = 1'b0;
         load_val_o[g] = 1'b0;
         if (bus_rst_i || sel_rst) begin
            load_en_o[g]  = 1'b1;
            load_val_o[g] = 1'b0;
         end else if (setup_hit) begin
            load_en_o[g]  = 1'b1;
            load_val_o[g] = bit_after(PID_DATA0);
         end else if (data_hit) begin
            load_en_o[g]  = 1'b1;
            load_val_o[g] = bit_after(rx_pid_i);
         end
      end
   end
endmodule

// File: rtl/dtog_cell.sv
module dtog_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic load_en_i,
   input  logic load_val_i,
   output logic bit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_o <= 1'b0;
      else if (load_en_i)
         bit_o <= load_val_i;
   end
endmodule

// File: rtl/dtog_tx_sel.sv
module dtog_tx_sel
   import dtog_pkg::*;
#(
   parameter int NUM_EP = 8,
   parameter int EPW    = 3
) (
   input  logic [NUM_EP-1:0] state_i,
   input  logic [EPW-1:0]    q_ep_i,
   input  logic [1:0]        q_kind_i,
   input  logic              q_status_i,
   output logic              q_toggle_o,
   output logic              q_tx_pid_o,
   output logic              q_na_o
);
   logic in_range;
   logic raw;

   assign in_range = int'(q_ep_i) < NUM_EP;

   always_comb begin
      raw = 1'b0;
      for (int i = 0; i < NUM_EP; i++)
         if (int'(q_ep_i) == i)
            raw = state_i[i];
   end

   assign q_toggle_o = in_range ? raw : 1'b0;
   assign q_na_o     = (ep_kind_t'(q_kind_i) == EP_ISO);

   always_comb begin
      if (q_na_o)
         q_tx_pid_o = PID_DATA0;
      else if (q_status_i)
         q_tx_pid_o = PID_DATA1;
      else
         q_tx_pid_o = q_toggle_o ? PID_DATA1 : PID_DATA0;
   end
endmodule

// File: rtl/dtog_tracker.sv
module dtog_tracker
   import dtog_pkg::*;
#(
   parameter int NUM_EP = 8,
   parameter int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_rst_i,
   input  logic           ep_rst_i,
   input  logic [EPW-1:0] ep_rst_num_i,
   input  logic           rx_valid_i,
   input  logic [EPW-1:0] rx_ep_i,
   input  logic           rx_pid_i,
   input  logic           rx_setup_i,
   input  logic [1:0]     rx_kind_i,
   input  logic [EPW-1:0] q_ep_i,
   input  logic [1:0]     q_kind_i,
   input  logic           q_status_i,
   output logic           q_toggle_o,
   output logic           q_tx_pid_o,
   output logic           q_na_o
);
   localparam int MAX_EP = 1 << EPW;

   if (NUM_EP < 1 || NUM_EP > 32) begin : g_bad_count
      $error("dtog_tracker: NUM_EP must lie in 1..32");
   end
   if (NUM_EP > MAX_EP) begin : g_bad_width
      $error("dtog_tracker: EPW too narrow for NUM_EP");
   end

   logic [NUM_EP-1:0] tog_q;
   logic [NUM_EP-1:0] load_en;
   logic [NUM_EP-1:0] load_val;

   dtog_rx_decode #(.NUM_EP(NUM_EP), .EPW(EPW)) i_dec (
      .bus_rst_i    (bus_rst_i),
      .ep_rst_i     (ep_rst_i),
      .ep_rst_num_i (ep_rst_num_i),
      .rx_valid_i   (rx_valid_i),
      .rx_ep_i      (rx_ep_i),
      .rx_pid_i     (rx_pid_i),
      .rx_setup_i   (rx_setup_i),
      .rx_kind_i    (rx_kind_i),
      .cur_i        (tog_q),
      .load_en_o    (load_en),
      .load_val_o   (load_val)
   );

   for (genvar g = 0; g < NUM_EP; g++) begin : g_cell
      dtog_cell i_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_en_i  (load_en[g]),
         .load_val_i (load_val[g]),
         .bit_o      (tog_q[g])
      );
   end

   dtog_tx_sel #(.NUM_EP(NUM_EP), .EPW(EPW)) i_sel (
      .state_i    (tog_q),
      .q_ep_i     (q_ep_i),
      .q_kind_i   (q_kind_i),
      .q_status_i (q_status_i),
      .q_toggle_o (q_toggle_o),
      .q_tx_pid_o (q_tx_pid_o),
      .q_na_o     (q_na_o)
   );
endmodule

// File: rtl/dtog_checker.sv
module dtog_checker #(
   parameter int NUM_EP = 8,
   parameter int EPW    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_rst_i,
   input logic              ep_rst_i,
   input logic [EPW-1:0]    ep_rst_num_i,
   input logic              rx_valid_i,
   input logic [EPW-1:0]    rx_ep_i,
   input logic              rx_pid_i,
   input logic              rx_setup_i,
   input logic [1:0]        rx_kind_i,
   input logic [1:0]        q_kind_i,
   input logic              q_status_i,
   input logic              q_toggle_o,
   input logic              q_tx_pid_o,
   input logic              q_na_o,
   input logic [NUM_EP-1:0] tog_q
);
   logic rx_in_range;
   logic rx_collide;
   assign rx_in_range = int'(rx_ep_i) < NUM_EP;
   assign rx_collide  = bus_rst_i || (ep_rst_i && ep_rst_num_i == rx_ep_i);

   AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> tog_q == '0); // R6

   AST_EP_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_rst_i && int'(ep_rst_num_i) < NUM_EP) |=> !tog_q[$past(ep_rst_num_i)]); // R5

   AST_SETUP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && rx_setup_i && rx_kind_i == 2'b00 && rx_in_range && !rx_collide)
      |=> tog_q[$past(rx_ep_i)]); // R4

   AST_MISMATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && !rx_setup_i && rx_in_range && !rx_collide && rx_pid_i != tog_q[rx_ep_i])
      |=> tog_q[$past(rx_ep_i)] == $past(tog_q[rx_ep_i])); // R3

   AST_ISO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid_i && rx_kind_i == 2'b01 && rx_in_range && !rx_collide)
      |=> tog_q[$past(rx_ep_i)] == $past(tog_q[rx_ep_i])); // R8

   AST_STATUS_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
      (q_status_i && q_kind_i != 2'b01) |-> q_tx_pid_o); // R7

   AST_ISO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (q_kind_i == 2'b01) |-> (q_na_o && !q_tx_pid_o)); // R8

   AST_PID_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_status_i && q_kind_i != 2'b01) |-> q_tx_pid_o == q_toggle_o); // R7
endmodule

bind dtog_tracker dtog_checker #(.NUM_EP(NUM_EP), .EPW(EPW)) i_dtog_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_rst_i    (bus_rst_i),
   .ep_rst_i     (ep_rst_i),
   .ep_rst_num_i (ep_rst_num_i),
   .rx_valid_i   (rx_valid_i),
   .rx_ep_i      (rx_ep_i),
   .rx_pid_i     (rx_pid_i),
   .rx_setup_i   (rx_setup_i),
   .rx_kind_i    (rx_kind_i),
   .q_kind_i     (q_kind_i),
   .q_status_i   (q_status_i),
   .q_toggle_o   (q_toggle_o),
   .q_tx_pid_o   (q_tx_pid_o),
   .q_na_o       (q_na_o),
   .tog_q        (tog_q)
);

// File: tb/test_dtog_tracker.sv
module test_dtog_tracker;
   localparam int NUM_EP = 8;
   localparam int EPW    = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_rst_i = 1'b0;
   logic           ep_rst_i = 1'b0;
   logic [EPW-1:0] ep_rst_num_i = '0;
   logic           rx_valid_i = 1'b0;
   logic [EPW-1:0] rx_ep_i = '0;
   logic           rx_pid_i = 1'b0;
   logic           rx_setup_i = 1'b0;
   logic [1:0]     rx_kind_i = 2'b10;
   logic [EPW-1:0] q_ep_i = '0;
   logic [1:0]     q_kind_i = 2'b10;
   logic           q_status_i = 1'b0;
   logic           q_toggle_o;
   logic           q_tx_pid_o;
   logic           q_na_o;

   int checks = 0;
   int errors = 0;
   logic mdl [NUM_EP];

   always #5 clk = ~clk;

   dtog_tracker #(.NUM_EP(NUM_EP)) i_dtog_tracker (.*);

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog (R9): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Bench model of one endpoint after a clock edge.
   function automatic logic mdl_next(input int ep, input logic cur);
      if (bus_rst_i) return 1'b0;
      if (ep_rst_i && int'(ep_rst_num_i) == ep) return 1'b0;
      if (!rx_valid_i || int'(rx_ep_i) != ep || rx_kind_i == 2'b01) return cur;
      if (rx_setup_i) return (rx_kind_i == 2'b00) ? 1'b1 : cur;
      if (rx_pid_i != cur) return cur;
      return rx_pid_i ? 1'b0 : 1'b1;
   endfunction

   task automatic step(input string tag,
                       input logic rv, input int re, input logic rp, input logic rs,
                       input logic [1:0] rk, input logic er, input int en, input logic br,
                       input int qe, input logic [1:0] qk, input logic qs);
      logic exp_tog, exp_na, exp_pid;
      rx_valid_i = rv; rx_ep_i = EPW'(re); rx_pid_i = rp; rx_setup_i = rs;
      rx_kind_i = rk; ep_rst_i = er; ep_rst_num_i = EPW'(en); bus_rst_i = br;
      q_ep_i = EPW'(qe); q_kind_i = qk; q_status_i = qs;
      #1;
      exp_tog = mdl[qe];
      exp_na  = (qk == 2'b01);
      exp_pid = exp_na ? 1'b0 : (qs ? 1'b1 : exp_tog);
      chk(tag, q_toggle_o, exp_tog);
      chk(qs ? "R7 status pid" : "R7 tx pid", q_tx_pid_o, exp_pid);
      chk("R8 na flag", q_na_o, exp_na);
      @(posedge clk);
      for (int e = 0; e < NUM_EP; e++) mdl[e] = mdl_next(e, mdl[e]);
      @(negedge clk);
   endtask

   task automatic idle_q(input string tag, input int qe, input logic [1:0] qk, input logic qs);
      step(tag, 1'b0, 0, 1'b0, 1'b0, 2'b10, 1'b0, 0, 1'b0, qe, qk, qs);
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int e = 0; e < NUM_EP; e++) mdl[e] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int e = 0; e < NUM_EP; e++) idle_q("R1", e, 2'b10, 1'b0);

      // R2: matching DATA0 sets, matching DATA1 clears
      step("R2", 1'b1, 3, 1'b0, 1'b0, 2'b10, 1'b0, 0, 1'b0, 3, 2'b10, 1'b0);
      idle_q("R2 after DATA0", 3, 2'b10, 1'b0);
      // R3: repeated DATA0 is a retry
      step("R3", 1'b1, 3, 1'b0, 1'b0, 2'b11, 1'b0, 0, 1'b0, 3, 2'b11, 1'b0);
      idle_q("R3 after retry", 3, 2'b11, 1'b0);
      step("R2", 1'b1, 3, 1'b1, 1'b0, 2'b10, 1'b0, 0, 1'b0, 3, 2'b10, 1'b0);
      idle_q("R2 after DATA1", 3, 2'b10, 1'b0);
      // R4: SETUP on control with DATA1 pid, SETUP flag on bulk ignored
      step("R4", 1'b1, 2, 1'b1, 1'b1, 2'b00, 1'b0, 0, 1'b0, 2, 2'b00, 1'b0);
      idle_q("R4 setup ctrl", 2, 2'b00, 1'b0);
      step("R4", 1'b1, 4, 1'b0, 1'b1, 2'b10, 1'b0, 0, 1'b0, 4, 2'b10, 1'b0);
      idle_q("R4 setup on bulk", 4, 2'b10, 1'b0);
      // R8: isochronous packet has no effect
      step("R8", 1'b1, 5, 1'b0, 1'b0, 2'b01, 1'b0, 0, 1'b0, 5, 2'b01, 1'b0);
      idle_q("R8 iso rx", 5, 2'b10, 1'b0);
      // R7: status stage forces DATA1 while bit is 0
      idle_q("R7", 5, 2'b00, 1'b1);
      // R5: endpoint reset beats packet in same cycle, neighbour kept
      step("R5", 1'b1, 3, 1'b0, 1'b0, 2'b10, 1'b0, 0, 1'b0, 3, 2'b10, 1'b0);
      step("R5", 1'b1, 3, 1'b1, 1'b0, 2'b10, 1'b1, 3, 1'b0, 3, 2'b10, 1'b0);
      idle_q("R5 reset wins", 3, 2'b10, 1'b0);
      idle_q("R5 neighbour kept", 2, 2'b00, 1'b0);
      // R6: bus reset beats SETUP, all cleared
      step("R6", 1'b1, 6, 1'b0, 1'b1, 2'b00, 1'b0, 0, 1'b1, 2, 2'b00, 1'b0);
      for (int e = 0; e < NUM_EP; e++) idle_q("R6 all clear", e, 2'b10, 1'b0);

      // R9: random traffic
      for (int n = 0; n < 3000; n++) begin
         step("R9",
              ($urandom % 3) != 0, $urandom % NUM_EP, 1'($urandom), ($urandom % 5) == 0,
              2'($urandom), ($urandom % 12) == 0, $urandom % NUM_EP, ($urandom % 200) == 0,
              $urandom % NUM_EP, 2'($urandom), ($urandom % 4) == 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule